// File: doc/BRIEF.md
# Delayed Lockstep Output Comparator

This block watches a pair of processor cores that run the same program in lockstep: a main core and a checker core. It holds the two cores two clock cycles apart. The inputs given to the main core reach the checker core two cycles later. The main core's outputs are also held back two cycles, so that they meet the checker's outputs for the same step of the program. The two aligned output buses are compared on every clock cycle. A duplicated interrupt controller is checked the same way: the vector from the main-side controller is delayed two cycles and compared with the vector from the checker-side controller.

The block has no split mode. Once the delay registers have filled after reset, comparison stays on until the next reset. Any mismatch raises a single error of the highest severity. This error is sticky and records which channel mismatched first. Only an explicit clear pulse removes it. A self-test input flips one bit of the delayed main output for one cycle, so that software can prove the comparator really detects a difference.

Top module: `lockstep_cmp`

## Requirements
- R1: `chk_in` equals the value `main_in` had two clock edges earlier.
- R2: When `chk_out` matches the `main_out` of two cycles earlier and `irq_chk` matches the `irq_main` of two cycles earlier, `err` stays low.
- R3: When comparison is on, a difference in any single bit between the delayed main output and `chk_out` sets `err` at the next edge, with `err_src` = 2'b01 (bit 0 marks the core channel).
- R4: When comparison is on, a difference in any single bit between the delayed `irq_main` and `irq_chk` sets `err` at the next edge, with `err_src` = 2'b10 (bit 1 marks the interrupt channel).
- R5: No mismatch is flagged during the first two clock edges after reset. `armed` goes high after the second edge and stays high until reset.
- R6: `err` and `err_src` hold their values after the first mismatch, whatever the later inputs are, until `err_clr` is pulsed.
- R7: A cycle with `err_clr` high clears `err` and `err_src`, unless a mismatch is present in that same cycle. In that case the new mismatch is latched.
- R8: If both channels mismatch in the same cycle that first sets the error, `err_src` = 2'b11.
- R9: While armed, `inject` high inverts bit 0 of the delayed main output for that cycle only. With otherwise matching cores this sets `err` with `err_src` = 2'b01. Before `armed` goes high, `inject` has no effect.
- R10: After reset, `err`, `err_src`, `armed` and `chk_in` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_in | input | IN_W | Input bundle fed to the main core |
| chk_in | output | IN_W | The same bundle, two cycles late, for the checker core |
| main_out | input | OUT_W | Main core output bus |
| chk_out | input | OUT_W | Checker core output bus |
| irq_main | input | IRQ_W | Vector from the main-side interrupt controller |
| irq_chk | input | IRQ_W | Vector from the checker-side interrupt controller |
| inject | input | 1 | Self-test: flip bit 0 of the delayed main output this cycle |
| err_clr | input | 1 | Clears the sticky error |
| err | output | 1 | Sticky highest-severity lockstep error |
| err_src | output | 2 | First mismatch channel: bit 0 core, bit 1 interrupt |
| armed | output | 1 | Comparison is active |

## Verification
The bench builds the block with an 8-bit input bundle, an 8-bit output bus and a 4-bit interrupt vector. At these widths every single-bit fault on both channels can be injected one at a time, each followed by a clear, and the input delay can be checked over a full sweep of byte values. The bench keeps its own two-entry history of the main-side values to produce correctly skewed checker traffic. It then checks suppression during the fill cycles, stickiness, clear against a new mismatch, the two-channel tie and the self-test flip.

// File: rtl/lockstep_cmp.sv
module lockstep_cmp #(
  parameter int IN_W  = 64,
  parameter int OUT_W = 64,
  parameter int IRQ_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  main_in,
  output logic [IN_W-1:0]  chk_in,
  input  logic [OUT_W-1:0] main_out,
  input  logic [OUT_W-1:0] chk_out,
  input  logic [IRQ_W-1:0] irq_main,
  input  logic [IRQ_W-1:0] irq_chk,
  input  logic             inject,
  input  logic             err_clr,
  output logic             err,
  output logic [1:0]       err_src,
  output logic             armed
);

  logic [IN_W-1:0]  in_d1, in_d2;
  logic [OUT_W-1:0] out_d1, out_d2, out_cmp;
  logic [IRQ_W-1:0] irq_d1, irq_d2;
  logic [1:0]       fill;
  logic [1:0]       hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_d1  <= '0;
      in_d2  <= '0;
      out_d1 <= '0;
      out_d2 <= '0;
      irq_d1 <= '0;
      irq_d2 <= '0;
      fill   <= '0;
    end else begin
      in_d1  <= main_in;
      in_d2  <= in_d1;
      out_d1 <= main_out;
      out_d2 <= out_d1;
      irq_d1 <= irq_main;
      irq_d2 <= irq_d1;
      if (!fill[1]) fill <= fill + 2'd1;
    end
  end

  assign chk_in  = in_d2;
  assign armed   = fill[1];
  assign out_cmp = out_d2 ^ {{(OUT_W-1){1'b0}}, inject};
  assign hit[0]  = armed && (out_cmp != chk_out);
  assign hit[1]  = armed && (irq_d2 != irq_chk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err     <= 1'b0;
      err_src <= 2'b00;
    end else if (err_clr || !err) begin
      err     <= |hit;
      err_src <= hit;
    end
  end

  assert_input_skew_R1: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> chk_in == $past(main_in, 2));

  assert_quiet_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !err);

  assert_armed_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err && !err_clr |=> err && $stable(err_src));

  assert_core_detect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !err && !inject && (chk_out != out_d2) |=> err && err_src[0]);

  assert_irq_detect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !err && (irq_chk != irq_d2) |=> err && err_src[1]);

  assert_inject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !err && inject && (chk_out == out_d2) |=> err && err_src[0]);

  assert_src_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err == (err_src != 2'b00));

endmodule

// File: tb/lockstep_cmp_bench.sv
module lockstep_cmp_bench;
  localparam int IN_W = 8, OUT_W = 8, IRQ_W = 4;

  logic clk = 0, rst_n = 0;
  logic [IN_W-1:0]  main_in = '0;
  logic [IN_W-1:0]  chk_in;
  logic [OUT_W-1:0] main_out = '0, chk_out = '0;
  logic [IRQ_W-1:0] irq_main = '0, irq_chk = '0;
  logic inject = 0, err_clr = 0;
  logic err, armed;
  logic [1:0] err_src;

  int checks = 0, errors = 0;
  logic [OUT_W-1:0] oh1 = '0, oh2 = '0;
  logic [IRQ_W-1:0] qh1 = '0, qh2 = '0;
  logic [IN_W-1:0]  ih1 = '0;
  bit done = 0;

  always #4 clk = ~clk;

  lockstep_cmp #(.IN_W(IN_W), .OUT_W(OUT_W), .IRQ_W(IRQ_W)) u_lockstep_cmp (
    .clk(clk), .rst_n(rst_n), .main_in(main_in), .chk_in(chk_in),
    .main_out(main_out), .chk_out(chk_out), .irq_main(irq_main), .irq_chk(irq_chk),
    .inject(inject), .err_clr(err_clr), .err(err), .err_src(err_src), .armed(armed));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(logic [OUT_W-1:0] m, logic [IRQ_W-1:0] q, logic [OUT_W-1:0] cm,
                     logic [IRQ_W-1:0] qm, logic inj, logic clr);
    main_out = m; chk_out = oh2 ^ cm;
    irq_main = q; irq_chk = qh2 ^ qm;
    inject = inj; err_clr = clr;
    @(posedge clk);
    oh2 = oh1; oh1 = m; qh2 = qh1; qh1 = q;
    @(negedge clk);
    inject = 0; err_clr = 0;
  endtask

  task automatic clear_err();
    cyc(8'h3c, 4'h5, '0, '0, 0, 1);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20;
    chk("R10 err", err, 0);
    chk("R10 src", err_src, 0);
    chk("R10 armed", armed, 0);
    chk("R10 chk_in", chk_in, 0);
    @(negedge clk); rst_n = 1;
    cyc(8'ha5, 4'h3, 8'hff, 4'hf, 1, 0);
    chk("R5 fill1 armed", armed, 0);
    chk("R5 fill1 err", err, 0);
    cyc(8'h5a, 4'hc, 8'hff, 4'hf, 1, 0);
    chk("R5 armed after two edges", armed, 1);
    chk("R5 err suppressed", err, 0);
    chk("R9 inject ignored when unarmed", err_src, 0);

    for (int v = 0; v < 256; v++) begin
      main_in = v[IN_W-1:0];
      cyc(v[7:0] ^ 8'h69, v[3:0], '0, '0, 0, 0);
      chk("R1 chk_in skew", chk_in, ih1);
      ih1 = v[IN_W-1:0];
      chk("R2 matched no error", err, 0);
    end

    for (int b = 0; b < OUT_W; b++) begin
      cyc(8'h11 << b, 4'h1, 8'h01 << b, '0, 0, 0);
      chk("R3 core bit err", err, 1);
      chk("R3 core bit src", err_src, 2'b01);
      cyc(8'h77, 4'h2, 8'hff, 4'hf, 0, 0);
      chk("R6 sticky src", err_src, 2'b01);
      clear_err();
      chk("R7 cleared", err, 0);
      chk("R7 cleared src", err_src, 0);
    end

    for (int b = 0; b < IRQ_W; b++) begin
      cyc(8'h42, 4'h9, '0, 4'h1 << b, 0, 0);
      chk("R4 irq bit err", err, 1);
      chk("R4 irq bit src", err_src, 2'b10);
      clear_err();
      chk("R7 cleared irq", err, 0);
    end

    cyc(8'h0f, 4'h6, 8'h80, 4'h8, 0, 0);
    chk("R8 both src", err_src, 2'b11);
    cyc(8'h10, 4'h1, 8'h00, 4'h0, 0, 1);
    chk("R7 clear clean", err, 0);

    cyc(8'h20, 4'h2, '0, '0, 0, 0);
    cyc(8'h21, 4'h3, '0, 4'h4, 0, 1);
    chk("R7 clear with new mismatch err", err, 1);
    chk("R7 clear with new mismatch src", err_src, 2'b10);
    clear_err();

    cyc(8'h30, 4'h0, '0, '0, 1, 0);
    chk("R9 inject err", err, 1);
    chk("R9 inject src", err_src, 2'b01);
    clear_err();
    cyc(8'h31, 4'h0, '0, '0, 0, 0);
    chk("R9 single cycle only", err, 0);
    chk("R2 still armed", armed, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule